// File: doc/BRIEF.md
# Sprite Page DMA Controller

This block copies one 256-byte memory page into the fixed sprite-data port at address 0x2004 by borrowing the bus of a 6502-style CPU. Software writes a page number to the trigger register. The block latches that number and waits for the current instruction to end. It then holds RDY low to stall the CPU, inserts one or two wait cycles, and runs 512 alternating bus cycles. Each pair reads a byte from the page and then writes it to the sprite port.

The block does not move data itself. It drives only the address and the read/write direction. Memory answers the read cycles. The sprite port takes the byte from the bus on the write cycles. The block decides when to take the bus from three inputs: an instruction-boundary flag, the CPU's current read/write direction and a cycle-parity flag. A whole transfer takes 513 cycles when it starts on an even cycle and 514 when it starts on an odd cycle.

Top module: `sprite_page_dma`

## Requirements
- R1: After reset, `rdy_o` is 1, `busy_o` is 0, `bus_own_o` is 0, `rw_o` is 1 (read) and `addr_o` is 0.
- R2: A cycle with `trig_wr_i`=1 while idle latches `trig_data_i` as the page number. The block takes no other action in that cycle, and `busy_o` stays 0 until an instruction boundary follows.
- R3: A latched request starts only in the cycle after one in which `sync_i`=1 and `cpu_rw_i`=1 (read). A boundary seen while the CPU is writing (`cpu_rw_i`=0) does not start the transfer.
- R4: The first busy cycle is a wait cycle: `rdy_o`=0, `busy_o`=1, `bus_own_o`=0.
- R5: The extra wait cycle depends on parity. If `odd_cycle_i`=1 during the first wait cycle, a second wait cycle follows. `busy_o` stays high for 513 cycles on an even start and 514 on an odd start.
- R6: The block owns the bus for 512 cycles. For i = 0 to 255 in ascending order, it drives a read (`rw_o`=1) of address page*256+i, then a write (`rw_o`=0) to address 0x2004.
- R7: When several trigger writes arrive before the boundary, as a read-modify-write instruction produces, exactly one transfer runs. It uses the page from the last write.
- R8: A trigger write while `busy_o`=1 is ignored, including on the final busy cycle. It changes neither the page in use nor the pending state, so a later boundary starts nothing. A boundary during a transfer does not restart it.
- R9: In the cycle after the final write to 0x2004, `rdy_o` returns to 1 and `busy_o` and `bus_own_o` return to 0. A trigger write in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_wr_i | input | 1 | Strobe for a write to the trigger register |
| trig_data_i | input | 8 | Data byte of the trigger write (page number) |
| sync_i | input | 1 | High in the opcode-fetch cycle of an instruction |
| cpu_rw_i | input | 1 | CPU bus direction this cycle, 1 = read |
| odd_cycle_i | input | 1 | Cycle parity, 1 = odd cycle |
| rdy_o | output | 1 | CPU ready; 0 stalls the CPU |
| addr_o | output | 16 | Bus address while the block owns the bus, else 0 |
| rw_o | output | 1 | Bus direction while owning, 1 = read; 1 when not owning |
| bus_own_o | output | 1 | The block is driving address and direction |
| busy_o | output | 1 | A transfer (wait or copy cycles) is in progress |

## Verification
A trigger write can fall in the same cycle as the end of a transfer. The bench places one write on the last busy cycle, which carries the final port write, and checks that a later boundary starts nothing. It places another write in the first idle cycle and checks that the next transfer copies that page. A boundary pulse and a trigger write are also injected in the middle of a transfer. A scoreboard fed with the expected address and direction sequence shows that the page and the beat order are unchanged.

// File: rtl/spdma_pkg.sv
package spdma_pkg;

    // Sequencer phases of one page transfer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HALT  = 2'd1,
        ST_ALIGN = 2'd2,
        ST_XFER  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/spdma_start_ctl.sv
// Holds the page number and the pending request until an instruction boundary.
module spdma_start_ctl #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_wr_i,
    input  logic [PAGE_W-1:0] trig_data_i,
    input  logic              busy_i,
    input  logic              sync_i,
    input  logic              cpu_rw_i,
    input  logic              start_ack_i,
    output logic              start_o,
    output logic [PAGE_W-1:0] page_o
);

    typedef struct packed {
        logic              pend;
        logic [PAGE_W-1:0] page;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (start_ack_i) begin
            regs_d.pend = 1'b0;
        end else if (trig_wr_i && !busy_i) begin
            // repeated writes before the boundary keep only the newest value
            regs_d.pend = 1'b1;
            regs_d.page = trig_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // the CPU can be held only while it reads, so the boundary must be a read
    assign start_o = regs_q.pend && sync_i && cpu_rw_i && !busy_i;
    assign page_o  = regs_q.page;

endmodule

// File: rtl/spdma_seq.sv
// Wait / alignment / copy sequencer.
module spdma_seq
    import spdma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             odd_i,
    output logic             start_ack_o,
    output logic             busy_o,
    output logic             rdy_o,
    output logic             own_o,
    output logic             rd_phase_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] beat;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.state = ST_HALT;
                end
            end
            ST_HALT: begin
                regs_d.beat  = '0;
                regs_d.state = odd_i ? ST_ALIGN : ST_XFER;
            end
            ST_ALIGN: begin
                regs_d.state = ST_XFER;
            end
            ST_XFER: begin
                regs_d.beat = regs_q.beat + 1'b1;
                if (regs_q.beat == LAST_BEAT) begin
                    regs_d.state = ST_IDLE;
                    regs_d.beat  = '0;
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, beat: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign start_ack_o = (regs_q.state == ST_IDLE) && start_i;
    assign busy_o      = (regs_q.state != ST_IDLE);
    assign rdy_o       = (regs_q.state == ST_IDLE);
    assign own_o       = (regs_q.state == ST_XFER);
    assign rd_phase_o  = ~regs_q.beat[0];
    assign idx_o       = regs_q.beat[CNT_W-1:1];

endmodule

// File: rtl/spdma_addr_gen.sv
// Address and direction drive for the copy beats.
module spdma_addr_gen #(
    parameter int              ADDR_W    = 16,
    parameter int              PAGE_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
    input  logic                     own_i,
    input  logic                     rd_phase_i,
    input  logic [PAGE_W-1:0]        page_i,
    input  logic [ADDR_W-PAGE_W-1:0] idx_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic                     rw_o
);

    always_comb begin
        addr_o = '0;
        rw_o   = 1'b1;
        if (own_i) begin
            rw_o   = rd_phase_i;
            addr_o = rd_phase_i ? {page_i, idx_i} : PORT_ADDR;
        end
    end

endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma #(
    parameter int                ADDR_W    = 16,
    parameter int                PAGE_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_wr_i,
    input  logic [PAGE_W-1:0] trig_data_i,
    input  logic              sync_i,
    input  logic              cpu_rw_i,
    input  logic              odd_cycle_i,
    output logic              rdy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rw_o,
    output logic              bus_own_o,
    output logic              busy_o
);

    localparam int IDX_W = ADDR_W - PAGE_W;

    logic              start;
    logic              start_ack;
    logic [PAGE_W-1:0] page;
    logic              rd_phase;
    logic [IDX_W-1:0]  idx;
    logic              busy;

    spdma_start_ctl #(.PAGE_W(PAGE_W)) u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_wr_i   (trig_wr_i),
        .trig_data_i (trig_data_i),
        .busy_i      (busy),
        .sync_i      (sync_i),
        .cpu_rw_i    (cpu_rw_i),
        .start_ack_i (start_ack),
        .start_o     (start),
        .page_o      (page)
    );

    spdma_seq #(.IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .odd_i       (odd_cycle_i),
        .start_ack_o (start_ack),
        .busy_o      (busy),
        .rdy_o       (rdy_o),
        .own_o       (bus_own_o),
        .rd_phase_o  (rd_phase),
        .idx_o       (idx)
    );

    spdma_addr_gen #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_addr (
        .own_i      (bus_own_o),
        .rd_phase_i (rd_phase),
        .page_i     (page),
        .idx_i      (idx),
        .addr_o     (addr_o),
        .rw_o       (rw_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/sprite_page_dma_chk.sv
module sprite_page_dma_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                PAGE_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic              cpu_rw_i,
    input logic              rdy_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              rw_o,
    input logic              bus_own_o,
    input logic              busy_o
);

    localparam int IDX_W   = ADDR_W - PAGE_W;
    localparam int MIN_LEN = 2 * (1 << IDX_W) + 1;
    localparam int LEN_W   = IDX_W + 3;

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (busy_o) begin
            len_q <= len_q + 1'b1;
        end else begin
            len_q <= '0;
        end
    end

    AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> $past(sync_i && cpu_rw_i)); // R3

    AST_WAIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!bus_own_o && !rdy_o)); // R4

    AST_XFER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (int'(len_q) == MIN_LEN || int'(len_q) == MIN_LEN + 1)); // R5

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own_o) |-> (rw_o && addr_o[IDX_W-1:0] == '0)); // R6

    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own_o && !rw_o) |-> $past(bus_own_o && rw_o)); // R6

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own_o && rw_o && $past(bus_own_o && rw_o, 2))
        |-> (addr_o[IDX_W-1:0] == $past(addr_o[IDX_W-1:0], 2) + 1'b1)); // R6

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own_o && rw_o && $past(bus_own_o && rw_o, 2))
        |-> (addr_o[ADDR_W-1:IDX_W] == $past(addr_o[ADDR_W-1:IDX_W], 2))); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (rdy_o && !bus_own_o
                           && $past(bus_own_o && !rw_o && addr_o == PORT_ADDR))); // R9

endmodule

bind sprite_page_dma sprite_page_dma_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .cpu_rw_i  (cpu_rw_i),
    .rdy_o     (rdy_o),
    .addr_o    (addr_o),
    .rw_o      (rw_o),
    .bus_own_o (bus_own_o),
    .busy_o    (busy_o)
);

// File: tb/sprite_page_dma_bench.sv
`timescale 1ns/1ps
module sprite_page_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_wr_i = 1'b0;
    logic [7:0]  trig_data_i = 8'h00;
    logic        sync_i = 1'b0;
    logic        cpu_rw_i = 1'b1;
    logic        odd_cycle_i = 1'b0;
    logic        rdy_o;
    logic [15:0] addr_o;
    logic        rw_o;
    logic        bus_own_o;
    logic        busy_o;

    always #2.5 clk = ~clk;

    sprite_page_dma u_sprite_page_dma (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_wr_i   (trig_wr_i),
        .trig_data_i (trig_data_i),
        .sync_i      (sync_i),
        .cpu_rw_i    (cpu_rw_i),
        .odd_cycle_i (odd_cycle_i),
        .rdy_o       (rdy_o),
        .addr_o      (addr_o),
        .rw_o        (rw_o),
        .bus_own_o   (bus_own_o),
        .busy_o      (busy_o)
    );

    typedef struct {
        logic [15:0] a;
        logic        rw;
    } item_t;

    item_t exp_q[$];
    int checks   = 0;
    int failures = 0;
    int exp_len  = 0;
    int exp_wait = 1;
    int run_len  = 0;
    bit prev_busy = 1'b0;
    bit reported  = 1'b0;
    int cycles    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one cycle step; parity follows the cycle count
    task automatic tick();
        @(negedge clk);
        odd_cycle_i = ~odd_cycle_i;
    endtask

    task automatic trigger(input logic [7:0] pg);
        trig_wr_i   = 1'b1;
        trig_data_i = pg;
        tick();
        trig_wr_i   = 1'b0;
    endtask

    task automatic expect_idle(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            tick();
            chk(!busy_o && rdy_o && !bus_own_o, req, "bus stays idle",
                {busy_o, rdy_o, bus_own_o}, 3'b010);
        end
    endtask

    // driver: push the expected beats, start at a boundary, step through;
    // an optional trigger write and boundary pulse land on busy cycle mid_at
    task automatic run_xfer(input logic [7:0] pg, input bit want_odd,
                            input int mid_at, input logic [7:0] mid_data);
        int len;
        len = 513 + int'(want_odd);
        for (int i = 0; i < 256; i++) begin
            exp_q.push_back('{a: {pg, i[7:0]}, rw: 1'b1});
            exp_q.push_back('{a: 16'h2004, rw: 1'b0});
        end
        exp_len  = len;
        exp_wait = 1 + int'(want_odd);
        tick();
        while (odd_cycle_i == want_odd) tick();
        sync_i   = 1'b1;
        cpu_rw_i = 1'b1;
        for (int k = 1; k <= len; k++) begin
            tick();
            trig_wr_i   = (k == mid_at);
            trig_data_i = mid_data;
            sync_i      = (mid_at != 0) && (k == mid_at + 1) && (k < len);
        end
        tick();
        trig_wr_i = 1'b0;
        sync_i    = 1'b0;
        chk(!busy_o && rdy_o && !bus_own_o, "R9", "released after last beat",
            {busy_o, rdy_o, bus_own_o}, 3'b010);
        chk(exp_q.size() == 0, "R6", "beats left unissued", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic pulse_sync(input bit rd);
        sync_i   = 1'b1;
        cpu_rw_i = rd;
        tick();
        sync_i   = 1'b0;
        cpu_rw_i = 1'b1;
    endtask

    // monitor: pops the scoreboard on every owned cycle, times each transfer
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) begin
                run_len++;
                if (run_len <= exp_wait) begin
                    chk(!bus_own_o && !rdy_o, (run_len == 1) ? "R4" : "R5",
                        "wait cycle", {bus_own_o, rdy_o}, 2'b00);
                end
            end
            if (bus_own_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected bus cycle", addr_o, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(addr_o == it.a && rw_o == it.rw, "R6", "beat addr/rw",
                        {addr_o, rw_o}, {it.a, it.rw});
                end
            end
            if (prev_busy && !busy_o) begin
                chk(run_len == exp_len, "R5", "busy length", run_len, exp_len);
                run_len = 0;
            end
            prev_busy = busy_o;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "R9", "watchdog expired", cycles, 150000);
            report();
        end
    end

    initial begin
        repeat (4) tick();
        chk(rdy_o && !busy_o && !bus_own_o && rw_o && addr_o == 16'h0, "R1",
            "reset outputs", {rdy_o, busy_o, bus_own_o, rw_o, addr_o}, 20'h90000);
        rst_n = 1'b1;
        tick();

        // R2: latch only, no activity without a boundary
        trigger(8'h03);
        expect_idle("R2", 6);
        // R3: boundary while the CPU writes does not start
        pulse_sync(1'b0);
        expect_idle("R3", 4);
        // even start, page 0x03
        run_xfer(8'h03, 1'b0, 0, 8'h00);

        // odd start, mid-transfer trigger and boundary are ignored (R8)
        trigger(8'hC1);
        run_xfer(8'hC1, 1'b1, 200, 8'h55);
        pulse_sync(1'b1);
        expect_idle("R8", 4);

        // R7: back-to-back writes, only the last page, one transfer
        trigger(8'h40);
        trigger(8'h80);
        run_xfer(8'h80, 1'b1, 0, 8'h00);
        pulse_sync(1'b1);
        expect_idle("R7", 4);

        // R8: write on the final busy cycle is dropped
        trigger(8'h12);
        run_xfer(8'h12, 1'b0, 513, 8'h77);
        pulse_sync(1'b1);
        expect_idle("R8", 4);

        // R9: write in the first idle cycle is taken
        trigger(8'h21);
        run_xfer(8'h21, 1'b1, 0, 8'h00);
        trigger(8'h5A);
        run_xfer(8'h5A, 1'b0, 0, 8'h00);

        repeat (3) tick();
        report();
    end

endmodule